// File: doc/BRIEF.md
# MDIO Management Master with Register Interface

This block lets a host processor read and write the management registers of Ethernet PHYs over the two-wire MDC/MDIO serial bus. Software programs it through a small bank of 32-bit registers. The bank holds a command word, outgoing data, returned data, a status word and a free scratch word. Writing a command word with its launch bit set produces one complete management frame on the serial side. The frame carries a preamble, start and opcode bits, the PHY and register addresses, a turnaround and sixteen data bits. Only one frame is in flight at any time.

The serial side drives MDC as a divided copy of the system clock. MDC idles low and is active only while a frame is running. MDIO is shown as three signals for an external tri-state pad: output value, output enable and input. For a read, the master releases the line before the turnaround. A PHY that does not drive the second turnaround bit low is reported through a status bit, and software takes this to mean that no device answers at that address.

Top module: `mdio_master`

## Requirements
- R1: After a synchronous active-low reset, every register reads as zero, MDC is low and the MDIO output enable is low.
- R2: Register offsets (byte address on `reg_addr`): 0x00 command, 0x04 scratch, 0x08 write data, 0x0C read data, 0x10 status. The scratch word reads back all 32 bits. Write data keeps bits 15:0 and reads zero above them. Writes to the read-data and status registers have no effect. A command write with bit 14 clear stores bits 12:0 and starts no frame.
- R3: In the command word, bits 4:0 are the register number, bits 9:5 the PHY address and bits 12:10 the raw start/opcode pattern. Writing 1 to bit 14 while idle launches a frame. Bit 14 then reads 1 until the frame's 64th MDC cycle has ended.
- R4: Every frame sends, MSB first, 32 ones, then 01, then the opcode equal to command bits 11:10 (10 for a read, pattern 110; 01 for a write, pattern 101), then the 5-bit PHY address and the 5-bit register number.
- R5: In a write frame (any pattern other than bits 11:10 = 10), the master drives the turnaround as 10 and then the 16 write-data bits MSB first. The output enable stays high for all 64 bits.
- R6: In a read frame, the output enable drops for bit 46 onward (turnaround and data). The 16 bits sampled on the rising MDC edges of bits 48..63 appear, first bit as bit 15, in read-data bits 15:0 when the frame ends.
- R7: Status bit 1 is set when the line is sampled high on the rising MDC edge of bit 47 of a read frame, and is cleared when any new frame is launched. All other status bits read 0.
- R8: MDC stays high and low for MDC_HALF system clocks each and is low whenever no frame runs. MDIO output and enable change only while MDC is low, and are sampled by the PHY on the rising edge.
- R9: A command write while busy is ignored: the frame in flight is unchanged, no second frame follows, and the stored command fields are unchanged.
- R10: The scratch register has no effect on the frames produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one clock per write |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | MDIO value driven when enabled |
| mdio_oe | output | 1 | MDIO output enable for the pad |
| mdio_i | input | 1 | MDIO value seen at the pad |

## Verification
The assertions assume that register writes are single-cycle strobes. They also assume that `mdio_i` matters only while the master has released the line, so nothing is claimed about it during driven bits. The bench's PHY model changes `mdio_i` only on falling MDC edges and holds the line high when it does not answer, as a pull-up would. It issues every command write as a clean one-clock strobe between clock edges, including the writes it makes on purpose while a frame is running.

// File: rtl/mdio_pkg.sv
// Shared definitions for the MDIO management master: register offsets,
// command-word bit positions and the stored command fields.
package mdio_pkg;
    localparam int unsigned BUS_W   = 32;
    localparam int unsigned OFS_W   = 5;
    localparam int unsigned FIELD_W = 5;
    localparam int unsigned DATA_W  = 16;
    localparam int unsigned PAT_W   = 3;
    localparam int unsigned GO_BIT  = 14;

    typedef enum logic [OFS_W-1:0] {
        OFS_CMD     = 5'h00,
        OFS_SCRATCH = 5'h04,
        OFS_WDATA   = 5'h08,
        OFS_RDATA   = 5'h0C,
        OFS_STAT    = 5'h10
    } reg_ofs_e;

    // Fields kept from the command word (bits 12:0).
    typedef struct packed {
        logic [PAT_W-1:0]   pat;
        logic [FIELD_W-1:0] phy;
        logic [FIELD_W-1:0] regn;
    } cmd_t;
endpackage

// File: rtl/mdio_mdc_gen.sv
// MDC generator: while run is high, toggles mdc every HALF system clocks,
// starting low. rise/fall strobe in the clock before mdc goes high/low.
// Assumes HALF >= 1. Holds mdc low and the divider cleared while idle.
module mdio_mdc_gen #(
    parameter int unsigned HALF = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise,
    output logic fall
);
    localparam int unsigned CNT_W = $clog2(HALF + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             mdc_q;
    logic             wrap;

    assign wrap = run && (cnt_q == CNT_W'(HALF - 1));

    // Divider counter and clock phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign mdc  = mdc_q;
    assign rise = wrap && !mdc_q;
    assign fall = wrap &&  mdc_q;
endmodule

// File: rtl/mdio_frame_engine.sv
// Frame engine: on start, loads a full management frame and shifts it out
// MSB first, advancing one bit per MDC fall. For reads, releases the line
// from the turnaround on, records a missing acknowledge and shifts in data.
// Assumes start arrives only while idle and rise/fall come from mdio_mdc_gen.
module mdio_frame_engine
    import mdio_pkg::*;
#(
    parameter int unsigned PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  cmd_t              cmd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rise,
    input  logic              fall,
    input  logic              mdio_i,
    output logic              active,
    output logic              done,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              no_resp,
    output logic [DATA_W-1:0] rx_data
);
    localparam int unsigned FRAME  = PRE_LEN + 32;
    localparam int unsigned CW     = $clog2(FRAME);
    localparam int unsigned TA1    = PRE_LEN + 14;
    localparam int unsigned TA2    = PRE_LEN + 15;
    localparam int unsigned DSTART = PRE_LEN + 16;

    logic [FRAME-1:0]  tx_q;
    logic [CW-1:0]     pos_q;
    logic              rd_q, active_q, oe_q, nack_q, done_q;
    logic [DATA_W-1:0] rx_q;
    logic [FRAME-1:0]  frame_w;
    logic              is_rd_w;

    assign is_rd_w = cmd.pat[1] && !cmd.pat[0];
    assign frame_w = {{PRE_LEN{1'b1}}, 2'b01, cmd.pat[1:0], cmd.phy, cmd.regn,
                      2'b10, wdata};

    // Frame sequencing, shift-out and shift-in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q     <= '0;
            pos_q    <= '0;
            rd_q     <= 1'b0;
            active_q <= 1'b0;
            oe_q     <= 1'b0;
            nack_q   <= 1'b0;
            done_q   <= 1'b0;
            rx_q     <= '0;
        end else begin
            done_q <= 1'b0;
            if (start && !active_q) begin
                tx_q     <= frame_w;
                pos_q    <= '0;
                rd_q     <= is_rd_w;
                active_q <= 1'b1;
                oe_q     <= 1'b1;
                nack_q   <= 1'b0;
            end else if (active_q) begin
                if (rise && rd_q) begin
                    if (pos_q == CW'(TA2))
                        nack_q <= mdio_i;
                    if (pos_q >= CW'(DSTART))
                        rx_q <= {rx_q[DATA_W-2:0], mdio_i};
                end
                if (fall) begin
                    tx_q <= {tx_q[FRAME-2:0], 1'b0};
                    if (pos_q == CW'(FRAME - 1)) begin
                        active_q <= 1'b0;
                        oe_q     <= 1'b0;
                        done_q   <= 1'b1;
                    end else begin
                        pos_q <= pos_q + 1'b1;
                        if (rd_q && pos_q == CW'(TA1 - 1))
                            oe_q <= 1'b0;
                    end
                end
            end
        end
    end

    assign active  = active_q;
    assign done    = done_q;
    assign mdio_o  = tx_q[FRAME-1];
    assign mdio_oe = oe_q;
    assign no_resp = nack_q;
    assign rx_data = rx_q;
endmodule

// File: rtl/mdio_master.sv
// MDIO management master top: register bank, launch control, MDC divider
// and frame engine. Assumes reg_wr is a one-clock strobe; reads are
// combinational on reg_addr. One frame at a time; commands while busy drop.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int unsigned MDC_HALF = 25,
    parameter int unsigned PRE_LEN  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [OFS_W-1:0] reg_addr,
    input  logic [BUS_W-1:0] reg_wdata,
    output logic [BUS_W-1:0] reg_rdata,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);
    cmd_t              cmd_q;
    logic [BUS_W-1:0]  scratch_q;
    logic [DATA_W-1:0] wdata_q, rdata_q, eng_rx;
    logic              eng_active, eng_done, eng_nack;
    logic              mdc_rise, mdc_fall;
    logic              cmd_wr, launch, cmd_rd;

    assign cmd_wr = reg_wr && (reg_addr == OFS_CMD);
    assign launch = cmd_wr && !eng_active && reg_wdata[GO_BIT];
    assign cmd_rd = cmd_q.pat[1] && !cmd_q.pat[0];

    // Register bank writes and read-data capture at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q     <= '0;
            scratch_q <= '0;
            wdata_q   <= '0;
            rdata_q   <= '0;
        end else begin
            if (cmd_wr && !eng_active)
                cmd_q <= cmd_t'(reg_wdata[$bits(cmd_t)-1:0]);
            if (reg_wr && reg_addr == OFS_SCRATCH)
                scratch_q <= reg_wdata;
            if (reg_wr && reg_addr == OFS_WDATA)
                wdata_q <= reg_wdata[DATA_W-1:0];
            if (eng_done && cmd_rd)
                rdata_q <= eng_rx;
        end
    end

    // Read-back multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CMD:     reg_rdata = {17'b0, eng_active, 1'b0, cmd_q};
            OFS_SCRATCH: reg_rdata = scratch_q;
            OFS_WDATA:   reg_rdata = {16'b0, wdata_q};
            OFS_RDATA:   reg_rdata = {16'b0, rdata_q};
            OFS_STAT:    reg_rdata = {30'b0, eng_nack, 1'b0};
            default:     reg_rdata = '0;
        endcase
    end

    mdio_mdc_gen #(.HALF(MDC_HALF)) u_mdc (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (eng_active),
        .mdc  (mdc),
        .rise (mdc_rise),
        .fall (mdc_fall)
    );

    mdio_frame_engine #(.PRE_LEN(PRE_LEN)) u_eng (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (launch),
        .cmd    (cmd_t'(reg_wdata[$bits(cmd_t)-1:0])),
        .wdata  (wdata_q),
        .rise   (mdc_rise),
        .fall   (mdc_fall),
        .mdio_i (mdio_i),
        .active (eng_active),
        .done   (eng_done),
        .mdio_o (mdio_o),
        .mdio_oe(mdio_oe),
        .no_resp(eng_nack),
        .rx_data(eng_rx)
    );
endmodule

// File: rtl/mdio_master_sva.sv
// Property checker for mdio_master, attached by bind below.
module mdio_master_sva
    import mdio_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [OFS_W-1:0] reg_addr,
    input logic [BUS_W-1:0] reg_wdata,
    input logic             mdc,
    input logic             mdio_o,
    input logic             mdio_oe,
    input logic             busy,
    input logic             is_read,
    input logic             nack
);
    // R8: MDC rests low between frames.
    a_r8_idle_mdc_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    // R8: the line only moves while MDC is low.
    a_r8_mdio_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R5: a write frame drives the line throughout.
    a_r5_write_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !is_read) |-> mdio_oe);

    // R3: a frame begins only after a command write with the start bit.
    a_r3_launch_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(reg_wr && reg_addr == OFS_CMD && reg_wdata[GO_BIT]));

    // R9: a command write in flight does not end or restart the frame.
    a_r9_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mdc && reg_wr && reg_addr == OFS_CMD) |=> busy);

    // R7: the no-response flag is clear once a frame is launched.
    a_r7_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !nack);
endmodule

bind mdio_master mdio_master_sva u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .mdc      (mdc),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .busy     (eng_active),
    .is_read  (cmd_rd),
    .nack     (eng_nack)
);

// File: tb/mdio_master_test.sv
`timescale 1ns/1ps
module mdio_master_test;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int nchk = 0;
    int nfail = 0;

    mdio_master #(.MDC_HALF(HALF)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #4 clk = ~clk;

    // PHY model state
    logic [63:0] cap_d, cap_oe;
    int          idx = 0;
    logic [15:0] resp = '0;
    logic        ack = 1'b1;
    realtime     last_edge = 0;
    logic        first_edge = 1'b1;
    logic        tm_bad = 1'b0;

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: run did not finish act=hung exp=done");
        summary();
        $finish;
    end

    // Capture each bit on the rising MDC edge; check R8 timing.
    always @(posedge mdc) begin
        if (idx < 64) begin
            cap_d[63-idx]  = mdio_o;
            cap_oe[63-idx] = mdio_oe;
        end
        idx++;
        if (!first_edge && ($realtime - last_edge) != HALF * 8.0) tm_bad = 1'b1;
        first_edge = 1'b0;
        last_edge = $realtime;
    end

    // Drive the response for the next bit on the falling MDC edge.
    always @(negedge mdc) begin
        if (($realtime - last_edge) != HALF * 8.0) tm_bad = 1'b1;
        last_edge = $realtime;
        if (idx == 47)                  mdio_i = ack ? 1'b0 : 1'b1;
        else if (idx >= 48 && idx < 64) mdio_i = resp[63-idx];
        else                            mdio_i = 1'b1;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int n = 0; n < 4000; n++) begin
            rd(5'h00, v);
            if (!v[14]) return;
        end
    endtask

    function automatic logic [63:0] exp_frame(input logic rdop, input logic [4:0] phy,
                                              input logic [4:0] rn, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (rdop ? 2'b10 : 2'b01), phy, rn, 2'b10, d};
    endfunction

    // One frame with full checks; R3..R8.
    task automatic frame(input logic rdop, input logic [4:0] phy, input logic [4:0] rn,
                         input logic [15:0] d, input logic a, input logic [15:0] r);
        logic [31:0] v;
        logic [63:0] ef;
        idx = 0; first_edge = 1'b1; tm_bad = 1'b0;
        ack = a; resp = r;
        if (!rdop) wr(5'h08, {16'hDEAD, d});
        wr(5'h00, {17'b0, 1'b1, 1'b0, (rdop ? 3'b110 : 3'b101), phy, rn});
        rd(5'h00, v);
        chk("R3 busy after launch", v[14], 1);
        rd(5'h10, v);
        chk("R7 status cleared at launch", v[1], 0);
        wait_idle();
        chk("R3 frame length", idx, 64);
        chk("R8 mdc half periods", tm_bad, 0);
        chk("R8 mdc idle low", mdc, 0);
        chk("R1 oe idle low", mdio_oe, 0);
        ef = exp_frame(rdop, phy, rn, d);
        if (rdop) begin
            chk("R4 read header", cap_d[63:18], ef[63:18]);
            chk("R6 read release", cap_oe, {{46{1'b1}}, 18'b0});
            rd(5'h0C, v);
            chk("R6 read data", v, {16'b0, r});
            rd(5'h10, v);
            chk("R7 no-response flag", v, {30'b0, !a, 1'b0});
        end else begin
            chk("R5 write frame", cap_d, ef);
            chk("R5 write drive", cap_oe, {64{1'b1}});
        end
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a <= 16; a += 4) begin
            rd(5'(a), v);
            chk("R1 register reset", v, 0);
        end
        chk("R1 mdc reset", mdc, 0);
        chk("R1 oe reset", mdio_oe, 0);

        // R2: register access
        wr(5'h04, 32'h89AB_CDEF); rd(5'h04, v); chk("R2 scratch", v, 32'h89AB_CDEF);
        wr(5'h08, 32'hABCD_1234); rd(5'h08, v); chk("R2 wdata width", v, 32'h0000_1234);
        wr(5'h0C, 32'hFFFF_FFFF); rd(5'h0C, v); chk("R2 rdata read-only", v, 0);
        wr(5'h10, 32'hFFFF_FFFF); rd(5'h10, v); chk("R2 status read-only", v, 0);
        idx = 0;
        wr(5'h00, 32'h0000_1A5C);
        repeat (40) @(negedge clk);
        rd(5'h00, v); chk("R2 cmd store without start", v, 32'h0000_1A5C);
        chk("R2 no frame without start", idx, 0);

        // Sweep all PHY addresses: write then read with varying acknowledge.
        for (int p = 0; p < 32; p++) begin
            logic [4:0]  rn;
            logic [15:0] d;
            rn = 5'((p * 11 + 5) % 32);
            d  = 16'(p * 16'h0811) ^ 16'hA5C3;
            if (p == 9) wr(5'h04, 32'h5555_AAAA);  // R10: scratch write mid-sweep
            frame(1'b0, 5'(p), rn, d, 1'b1, 16'h0);
            frame(1'b1, 5'(p), 5'(31 - p), 16'h0, (p % 5) != 3, ~d + 16'(p));
        end
        rd(5'h04, v); chk("R10 scratch retained, frames unaffected", v, 32'h5555_AAAA);

        // R7: no-response then answered read clears the flag
        frame(1'b1, 5'd3, 5'd1, 16'h0, 1'b0, 16'h1234);
        frame(1'b1, 5'd3, 5'd1, 16'h0, 1'b1, 16'h8001);

        // R9: command writes while busy are ignored
        idx = 0; first_edge = 1'b1; tm_bad = 1'b0; ack = 1'b1; resp = 16'hC3C3;
        wr(5'h00, {17'b0, 1'b1, 1'b0, 3'b110, 5'd17, 5'd9});
        repeat (20) @(negedge clk);
        wr(5'h00, {17'b0, 1'b1, 1'b0, 3'b101, 5'd2, 5'd30});
        wait_idle();
        repeat (200) @(negedge clk);
        chk("R9 single frame", idx, 64);
        chk("R9 frame unchanged", cap_d[63:18], exp_frame(1'b1, 5'd17, 5'd9, 16'h0) >> 18);
        rd(5'h00, v); chk("R9 fields unchanged", v, {17'b0, 1'b0, 1'b0, 3'b110, 5'd17, 5'd9});
        rd(5'h0C, v); chk("R9 read result", v, 32'h0000_C3C3);

        summary();
        $finish;
    end
endmodule